// File: doc/BRIEF.md
# Inter-Packet Gap Compliance Monitor

This block sits beside a serial packet transmitter and reports when the idle time between two packets is shorter than the minimum that software has programmed. It snoops the transmitter's bus-side register write port to learn the programmed minimum gap and the transmit clock divisor. From these two values it works out, at run time, how many bus clock cycles the line must stay idle. No fixed constant is built in.

The monitor watches the transmitter's valid line in the bus clock domain. A packet ends in the cycle where valid is low after being high. The next packet starts at the following rising edge. The monitor counts the low cycles in between. When the next packet starts too early, it pulls its ok output low in that same cycle and sets a sticky violation flag. If software rewrites the gap, divisor or command-set register while the line is idle, the timing rule for that gap is no longer well defined, so that gap is not judged.

Top module: `gap_monitor`

## Requirements
- R1: The required gap in bus cycles is div × (dly + 1). Here dly is bits [7:0] of the last write to address DLY_ADDR (default 'h04) and div is bits [7:0] of the last write to address DIV_ADDR (default 'h08).
- R2: The gap is the number of consecutive cycles with tx_valid low, counted from the first low cycle after a high cycle. When this count is at least the required gap at the next rising cycle of tx_valid, gap_ok stays 1.
- R3: When the gap is shorter than the required gap, gap_ok is 0 during the cycle in which tx_valid rises. It is 1 in every other cycle.
- R4: gap_violation becomes 1 in the cycle after gap_ok is 0, and then stays 1 until reset.
- R5: A write to DLY_ADDR, DIV_ADDR or CSET_ADDR (default 'h0C) in any low cycle of a gap waives the check for that gap, so gap_ok stays 1 at its end.
- R6: A write to CCLR_ADDR (default 'h10) or to any other address during a gap does not waive the check.
- R7: After reset, dly is 0 and div is 1. Out of reset, gap_ok is 1 and gap_violation is 0. The first rising edge of tx_valid after reset is not checked.
- R8: A new dly or div value applies to every gap that ends after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Snooped register write address |
| reg_wr | input | 1 | Snooped register write strobe |
| reg_wdata | input | DATA_W | Snooped register write data |
| tx_valid | input | 1 | Transmitter valid line, sampled on clk |
| gap_ok | output | 1 | 0 only in a cycle where a gap that is too short ends |
| gap_violation | output | 1 | Sticky: set after the first short gap |

## Verification
The hardest cases to reach are register writes that land inside an idle gap. Some of these waive the check and some must not. The driver task takes a cycle index inside the gap and a target address. It pulses the write strobe on exactly that low cycle, including the very first one. This lets the same short gap be tried with a waiving address, with the command-clear address and with an unrelated address. A waived write that also changes the delay is then followed by gaps that are judged against the new requirement.

// File: rtl/gm_pkg.sv
package gm_pkg;
    // which snooped register a write targets
    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_DLY,
        TGT_DIV,
        TGT_CSET,
        TGT_CCLR
    } reg_tgt_e;
endpackage

// File: rtl/gm_reg_snoop.sv
module gm_reg_snoop #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int FLD_W = 8,
    parameter logic [ADDR_W-1:0] DLY_ADDR = 'h04,
    parameter logic [ADDR_W-1:0] DIV_ADDR = 'h08,
    parameter logic [ADDR_W-1:0] CSET_ADDR = 'h0C,
    parameter logic [ADDR_W-1:0] CCLR_ADDR = 'h10,
    localparam int REQ_W = 2 * FLD_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [REQ_W-1:0]  req_len_o,
    output logic              cfg_hit_o
);
    import gm_pkg::*;

    typedef struct packed {
        logic [FLD_W-1:0] dly;
        logic [FLD_W-1:0] div;
    } snoop_st_t;

    snoop_st_t st_d, st_q;
    reg_tgt_e  tgt;

    always_comb begin
        tgt = TGT_NONE;
        if (reg_wr) begin
            if (reg_addr == DLY_ADDR)       tgt = TGT_DLY;
            else if (reg_addr == DIV_ADDR)  tgt = TGT_DIV;
            else if (reg_addr == CSET_ADDR) tgt = TGT_CSET;
            else if (reg_addr == CCLR_ADDR) tgt = TGT_CCLR;
        end
    end

    always_comb begin
        st_d = st_q;
        case (tgt)
            TGT_DLY: st_d.dly = reg_wdata[FLD_W-1:0];
            TGT_DIV: st_d.div = reg_wdata[FLD_W-1:0];
            default: ;
        endcase
        cfg_hit_o = (tgt == TGT_DLY) || (tgt == TGT_DIV) || (tgt == TGT_CSET);
        req_len_o = REQ_W'(st_q.div) * (REQ_W'(st_q.dly) + REQ_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.dly <= '0;
            st_q.div <= FLD_W'(1);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/gm_gap_tracker.sv
module gm_gap_tracker #(
    parameter int REQ_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             cfg_hit,
    input  logic [REQ_W-1:0] req_len,
    output logic             rise_o,
    output logic             waived_o,
    output logic             short_o
);
    localparam logic [REQ_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             prev;
        logic             in_gap;
        logic             waived;
        logic [REQ_W-1:0] cnt;
    } trk_st_t;

    trk_st_t st_d, st_q;
    logic    fall, rise;

    always_comb begin
        fall = !valid && st_q.prev;
        rise = valid && !st_q.prev;
        st_d = st_q;
        st_d.prev = valid;
        if (fall) begin
            st_d.in_gap = 1'b1;
            st_d.cnt    = REQ_W'(1);
            st_d.waived = cfg_hit;
        end else if (!valid && st_q.in_gap) begin
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + REQ_W'(1);
            st_d.waived = st_q.waived || cfg_hit;
        end else if (rise) begin
            st_d.in_gap = 1'b0;
            st_d.waived = 1'b0;
        end
        rise_o   = rise;
        waived_o = st_q.waived;
        short_o  = rise && st_q.in_gap && !st_q.waived && (st_q.cnt < req_len);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/gap_monitor.sv
module gap_monitor #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int FLD_W = 8,
    parameter logic [ADDR_W-1:0] DLY_ADDR = 'h04,
    parameter logic [ADDR_W-1:0] DIV_ADDR = 'h08,
    parameter logic [ADDR_W-1:0] CSET_ADDR = 'h0C,
    parameter logic [ADDR_W-1:0] CCLR_ADDR = 'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              tx_valid,
    output logic              gap_ok,
    output logic              gap_violation
);
    localparam int REQ_W = 2 * FLD_W + 1;

    logic [REQ_W-1:0] req_len;
    logic             cfg_hit;
    logic             gap_rise;
    logic             gap_waived;
    logic             gap_short;
    logic             viol_d, viol_q;

    gm_reg_snoop #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLD_W(FLD_W),
        .DLY_ADDR(DLY_ADDR), .DIV_ADDR(DIV_ADDR),
        .CSET_ADDR(CSET_ADDR), .CCLR_ADDR(CCLR_ADDR)
    ) u_snoop (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .req_len_o(req_len), .cfg_hit_o(cfg_hit)
    );

    gm_gap_tracker #(.REQ_W(REQ_W)) u_track (
        .clk(clk), .rst_n(rst_n),
        .valid(tx_valid), .cfg_hit(cfg_hit), .req_len(req_len),
        .rise_o(gap_rise), .waived_o(gap_waived), .short_o(gap_short)
    );

    always_comb begin
        viol_d        = viol_q || gap_short;
        gap_ok        = !gap_short;
        gap_violation = viol_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) viol_q <= 1'b0;
        else        viol_q <= viol_d;
    end
endmodule

// File: rtl/gm_chk.sv
module gm_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic gap_ok,
    input logic gap_violation,
    input logic gap_rise,
    input logic gap_waived
);
    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap_violation |=> gap_violation);
    // R4
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gap_ok |=> gap_violation);
    // R3
    ok_low_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gap_ok |-> tx_valid);
    // R2
    ok_when_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gap_rise |-> gap_ok);
    // R5
    waived_gap_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_rise && gap_waived) |-> gap_ok);
    // R7
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!gap_violation && gap_ok));
endmodule

bind gap_monitor gm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid),
    .gap_ok(gap_ok), .gap_violation(gap_violation),
    .gap_rise(gap_rise), .gap_waived(gap_waived)
);

// File: tb/tb_gap_monitor.sv
module tb_gap_monitor;
    localparam logic [7:0] A_DLY = 8'h04, A_DIV = 8'h08, A_CSET = 8'h0C;
    localparam logic [7:0] A_CCLR = 8'h10, A_OTHER = 8'h20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       tx_valid = 1'b0;
    logic       gap_ok, gap_violation;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int tb_dly = 0, tb_div = 1;

    typedef struct {
        bit    ok;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    gap_monitor dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .tx_valid(tx_valid),
        .gap_ok(gap_ok), .gap_violation(gap_violation)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // monitor: at each rising cycle of tx_valid, pop and compare gap_ok
    logic mon_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && tx_valid && !mon_prev && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(gap_ok, e.ok, e.tag);
        end
        mon_prev <= rst_n ? tx_valid : 1'b0;
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        tick();
        rst_n = 1'b0; tx_valid = 1'b0; reg_wr = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tb_dly = 0; tb_div = 1;
        tick();
        tx_valid = 1'b1;
        tick();
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        tick();
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        if (a == A_DLY) tb_dly = d;
        if (a == A_DIV) tb_div = d;
        tick();
        reg_wr = 1'b0;
    endtask

    // driver: low for g cycles (optional write on low cycle wr_at), then a packet
    task automatic run_gap(input int g, input int wr_at, input logic [7:0] wa,
                           input logic [7:0] wd, input bit waive, input string tag);
        exp_t e;
        for (int i = 0; i < g; i++) begin
            tick();
            tx_valid = 1'b0;
            reg_wr = (i == wr_at);
            reg_addr = wa; reg_wdata = wd;
        end
        e.ok = waive || (g >= tb_div * (tb_dly + 1));
        e.tag = tag;
        exp_q.push_back(e);
        if (wr_at >= 0 && wa == A_DLY) tb_dly = wd;
        if (wr_at >= 0 && wa == A_DIV) tb_div = wd;
        tick();
        tx_valid = 1'b1; reg_wr = 1'b0;
        tick();
    endtask

    initial begin
        repeat (2) tick();
        rst_n = 1'b1;
        @(negedge clk);
        chk(gap_ok, 1'b1, "R7 ok after reset");
        chk(gap_violation, 1'b0, "R7 sticky clear after reset");
        tick(); tx_valid = 1'b1; tick();
        run_gap(1, -1, 0, 0, 0, "R7 default required gap 1");

        wr(A_DIV, 3); wr(A_DLY, 2);
        run_gap(9, -1, 0, 0, 0, "R2 gap equal to required (R1 9)");
        run_gap(10, -1, 0, 0, 0, "R2 gap above required");
        @(negedge clk);
        chk(gap_violation, 1'b0, "R4 no violation yet");
        run_gap(8, -1, 0, 0, 0, "R3 gap one below required");
        @(negedge clk);
        chk(gap_violation, 1'b1, "R4 sticky set");
        chk(gap_ok, 1'b1, "R3 ok back high after violation cycle");
        run_gap(12, -1, 0, 0, 0, "R2 long gap after violation");
        @(negedge clk);
        chk(gap_violation, 1'b1, "R4 sticky held");

        do_reset();
        @(negedge clk);
        chk(gap_violation, 1'b0, "R7 reset clears sticky");
        wr(A_DIV, 4);
        run_gap(3, -1, 0, 0, 0, "R1 div 4 dly 0 short gap");
        run_gap(4, -1, 0, 0, 0, "R1 div 4 dly 0 exact gap");

        do_reset();
        wr(A_DLY, 5); wr(A_DIV, 2);
        run_gap(3, 1, A_DLY, 5, 1, "R5 delay write waives");
        run_gap(3, 0, A_CSET, 8'h01, 1, "R5 cmd-set write at first low waives");
        run_gap(2, 1, A_DIV, 2, 1, "R5 divisor write waives");
        @(negedge clk);
        chk(gap_violation, 1'b0, "R5 no violation from waived gaps");
        run_gap(3, 1, A_CCLR, 8'h01, 0, "R6 cmd-clear write does not waive");

        do_reset();
        wr(A_DLY, 5); wr(A_DIV, 2);
        run_gap(3, 2, A_OTHER, 8'h07, 0, "R6 unrelated write does not waive");

        do_reset();
        wr(A_DLY, 5); wr(A_DIV, 2);
        run_gap(3, 0, A_DLY, 1, 1, "R8 waived gap with new delay");
        run_gap(4, -1, 0, 0, 0, "R8 new requirement met");
        run_gap(3, -1, 0, 0, 0, "R8 new requirement short");

        repeat (2) tick();
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 pending expectations actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R2 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule